// File: doc/BRIEF.md
# Three-Level Cache Inclusion Controller

This block tracks, at tag level only, where cache lines live in a three-level hierarchy that serves one core: a private first level, a private second level and a shared third level. A request names a line address and says whether it is a demand access or a prefetch, and whether it is a store. The controller probes the levels from the nearest outward. When every level misses, it fetches the line from external memory. It then installs the line in every level that lacked it.

The two inclusion policies differ. The third level is strictly inclusive: when it evicts a line, that line is first invalidated in the private levels, and then a memory write follows if any copy was dirty. The second level is non-inclusive: its evictions leave the first level alone. A dirty line evicted from the first level is written to the second level if that level still holds it. Otherwise it goes to the third level, which holds every privately cached line.

The controller handles one request at a time. `busy` stays high from acceptance until the `done` cycle. Requests offered while `busy` is high are dropped.

Top module: `cache_incl_ctrl`

## Requirements
- R1: Levels are probed in the order first, second, third. `done_src` reports the first level that hit, encoded 0 = first level, 1 = second level, 2 = third level, 3 = memory. `mem_rd_valid` is raised only for code 3 and holds its line stable until `mem_rd_done`.
- R2: After a request completes, the line is present in every level. A repeat of the request reports code 0. Once the line has been displaced from the first level only, the next access reports code 1. Once it has been displaced from the first and second levels, the next access reports code 2.
- R3: Each level is direct-mapped and picks its own victim from its own index. The first level uses line mod 8. The second level uses (line XOR (line >> 4)) mod 16. The third level uses line mod 32.
- R4: When the third level evicts a valid line, one `inv_valid` pulse carries that line. `inv_l1` and `inv_l2` mark which private levels held it, and afterwards that line misses in every level. No pulse appears when neither private level holds the victim.
- R5: An eviction from the second level produces no invalidation, and the first level keeps its copy: a later access reports code 0.
- R6: A prefetch (`req_pf` = 1) takes the same lookup and fill path as a demand access and gives the same `done_src`. `done_pf` echoes the flag at `done`.
- R7: A store (`req_wr` = 1) marks the line dirty in the first level. If a dirty first-level victim is absent from the second level, it marks the third-level copy dirty, which later produces a memory write.
- R8: When the victim of a third-level fill is dirty in any level, exactly one `mem_wr_valid` pulse carries that line, in a later cycle than its invalidation pulse. A clean victim produces no write.
- R9: `busy` rises in the cycle after acceptance and falls in the cycle after `done`. A request with no fill or memory access keeps `busy` high for 2 cycles. A miss with a 3-cycle memory response and no victim keeps it high for 8 cycles. Requests offered while `busy` is high are ignored.
- R10: After reset, `busy`, `done` and the memory strobes are low and every level is empty, so the first access to any line reports code 3.
- R11: A dirty first-level victim that is still held in the second level marks the second-level copy dirty. When the second level later evicts that copy, the third-level copy becomes dirty, which results in a memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered; taken when `busy` is low |
| req_line | input | LINE_W | Line address of the request |
| req_pf | input | 1 | 1 = prefetch, 0 = demand |
| req_wr | input | 1 | 1 = store, marks the line dirty |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| done_src | output | 2 | Level that supplied the line (R1 encoding) |
| done_pf | output | 1 | Prefetch flag of the completed request |
| mem_rd_valid | output | 1 | External read request, held until response |
| mem_rd_line | output | LINE_W | Line to read |
| mem_rd_done | input | 1 | Read response strobe |
| mem_wr_valid | output | 1 | One-cycle write-back strobe |
| mem_wr_line | output | LINE_W | Line being written back |
| inv_valid | output | 1 | One-cycle back-invalidation strobe |
| inv_line | output | LINE_W | Line invalidated in the private levels |
| inv_l1 | output | 1 | First level held the line |
| inv_l2 | output | 1 | Second level held the line |

## Verification
The assertions check the following on every cycle:
- `busy` rises after acceptance and drops after `done`.
- The memory read holds its line until it is answered.
- Each invalidation names at least one private level.
- A write-back that follows an invalidation carries the same line.
- The prefetch flag stays stable through a request.

Only the bench's scenarios can show the rest: which level reports a hit for a given access history, that the differing index functions choose different victims, that a second-level eviction spares the first level, and that dirty state travels from a store through the levels until it reaches a memory write.

// File: rtl/cic_pkg.sv
// Shared types for the cache inclusion controller.
// Assumes: one request in flight; all addresses are line addresses.
package cic_pkg;
    typedef enum logic [1:0] {
        OP_NONE,
        OP_INSTALL,
        OP_INVAL,
        OP_MARK
    } tag_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LOOKUP,
        S_MEMRD,
        S_L3FILL,
        S_INVAL,
        S_MEMWR,
        S_L2FILL,
        S_L1FILL,
        S_FIN
    } cic_state_e;

    localparam logic [1:0] SRC_L1  = 2'd0;
    localparam logic [1:0] SRC_L2  = 2'd1;
    localparam logic [1:0] SRC_L3  = 2'd2;
    localparam logic [1:0] SRC_MEM = 2'd3;
endpackage

// File: rtl/cic_tag_array.sv
// Direct-mapped tag array holding full line numbers with valid and dirty bits.
// One combinational lookup port reports hit and the occupant of the indexed
// set; one operation port installs, invalidates or marks dirty per cycle.
// Assumes: LINE_W >= 2*IDX_W when FOLD is set.
module cic_tag_array
    import cic_pkg::*;
#(
    parameter int SETS   = 8,
    parameter int LINE_W = 26,
    parameter bit FOLD   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic              occ_valid,
    output logic              occ_dirty,
    output logic [LINE_W-1:0] occ_line,
    input  tag_op_e           op,
    input  logic [LINE_W-1:0] op_line,
    input  logic              op_dirty
);
    localparam int IDX_W = $clog2(SETS);

    logic              valid_q [SETS];
    logic              dirty_q [SETS];
    logic [LINE_W-1:0] tag_q   [SETS];
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  op_idx;

    // Index function: plain low bits, or low bits folded with the next field.
    generate
        if (FOLD) begin : g_fold
            assign lk_idx = lk_line[IDX_W-1:0] ^ lk_line[2*IDX_W-1:IDX_W];
            assign op_idx = op_line[IDX_W-1:0] ^ op_line[2*IDX_W-1:IDX_W];
        end else begin : g_plain
            assign lk_idx = lk_line[IDX_W-1:0];
            assign op_idx = op_line[IDX_W-1:0];
        end
    endgenerate

    // Lookup: compare the stored line and expose the occupant for victim use.
    always_comb begin
        occ_valid = valid_q[lk_idx];
        occ_dirty = dirty_q[lk_idx];
        occ_line  = tag_q[lk_idx];
        lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_line);
    end

    // Update: apply one operation per cycle, clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= 1'b0;
                dirty_q[s] <= 1'b0;
                tag_q[s]   <= '0;
            end
        end else begin
            case (op)
                OP_INSTALL: begin
                    valid_q[op_idx] <= 1'b1;
                    dirty_q[op_idx] <= op_dirty;
                    tag_q[op_idx]   <= op_line;
                end
                OP_INVAL: begin
                    if (valid_q[op_idx] && tag_q[op_idx] == op_line) begin
                        valid_q[op_idx] <= 1'b0;
                        dirty_q[op_idx] <= 1'b0;
                    end
                end
                OP_MARK: begin
                    if (valid_q[op_idx] && tag_q[op_idx] == op_line)
                        dirty_q[op_idx] <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cache_incl_ctrl.sv
// Sequencer for a private first level, a non-inclusive private second level
// and an inclusive shared third level. It probes the levels nearest first and
// fills the outer level first. Victims of the third level are back-invalidated
// in the private levels before any memory write-back.
// Assumes: one request at a time; memory answers every read with mem_rd_done.
module cache_incl_ctrl
    import cic_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int L1_SETS    = 8,
    parameter int L2_SETS    = 16,
    parameter int L3_SETS    = 32,
    localparam int LINE_W    = ADDR_W - $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_pf,
    input  logic              req_wr,
    output logic              busy,
    output logic              done,
    output logic [1:0]        done_src,
    output logic              done_pf,
    output logic              mem_rd_valid,
    output logic [LINE_W-1:0] mem_rd_line,
    input  logic              mem_rd_done,
    output logic              mem_wr_valid,
    output logic [LINE_W-1:0] mem_wr_line,
    output logic              inv_valid,
    output logic [LINE_W-1:0] inv_line,
    output logic              inv_l1,
    output logic              inv_l2
);
    localparam int NLV = 3;

    cic_state_e        state_q;
    logic [LINE_W-1:0] line_q, vic_q;
    logic              pf_q, wr_q, inv1_q, inv2_q, wb_q;
    logic [1:0]        src_q;

    logic [NLV-1:0]    lk_hit, occ_valid, occ_dirty, op_dirty;
    logic [LINE_W-1:0] lk_line  [NLV];
    logic [LINE_W-1:0] occ_line [NLV];
    logic [LINE_W-1:0] op_line  [NLV];
    tag_op_e           op       [NLV];

    // One tag array per level; the second level uses the folded index.
    for (genvar lv = 0; lv < NLV; lv++) begin : g_lvl
        localparam int LV_SETS = (lv == 0) ? L1_SETS : (lv == 1) ? L2_SETS : L3_SETS;
        cic_tag_array #(.SETS(LV_SETS), .LINE_W(LINE_W), .FOLD(lv == 1)) u_tags (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_line  (lk_line[lv]),
            .lk_hit   (lk_hit[lv]),
            .occ_valid(occ_valid[lv]),
            .occ_dirty(occ_dirty[lv]),
            .occ_line (occ_line[lv]),
            .op       (op[lv]),
            .op_line  (op_line[lv]),
            .op_dirty (op_dirty[lv])
        );
    end

    // Lookup steering: the request line, or a victim probed in another level.
    always_comb begin
        for (int l = 0; l < NLV; l++) lk_line[l] = line_q;
        if (state_q == S_L3FILL) begin
            lk_line[0] = occ_line[2];
            lk_line[1] = occ_line[2];
        end else if (state_q == S_L1FILL) begin
            lk_line[1] = occ_line[0];
        end
    end

    // Tag operations issued by each state.
    always_comb begin
        for (int l = 0; l < NLV; l++) begin
            op[l]      = OP_NONE;
            op_line[l] = line_q;
        end
        op_dirty = '0;
        case (state_q)
            S_LOOKUP: if (lk_hit[0] && wr_q) op[0] = OP_MARK;
            S_L3FILL: op[2] = OP_INSTALL;
            S_INVAL: begin
                op[0] = OP_INVAL;  op_line[0] = vic_q;
                op[1] = OP_INVAL;  op_line[1] = vic_q;
            end
            S_L2FILL: begin
                op[1] = OP_INSTALL;
                if (occ_valid[1] && occ_dirty[1]) begin
                    op[2] = OP_MARK;  op_line[2] = occ_line[1];
                end
            end
            S_L1FILL: begin
                op[0]       = OP_INSTALL;
                op_dirty[0] = wr_q;
                if (occ_valid[0] && occ_dirty[0]) begin
                    if (lk_hit[1]) begin
                        op[1] = OP_MARK;  op_line[1] = occ_line[0];
                    end else begin
                        op[2] = OP_MARK;  op_line[2] = occ_line[0];
                    end
                end
            end
            default: ;
        endcase
    end

    // Sequencer: accept, probe, fetch, fill outermost first, then complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            line_q  <= '0;
            vic_q   <= '0;
            pf_q    <= 1'b0;
            wr_q    <= 1'b0;
            inv1_q  <= 1'b0;
            inv2_q  <= 1'b0;
            wb_q    <= 1'b0;
            src_q   <= SRC_L1;
        end else begin
            case (state_q)
                S_IDLE: if (req_valid) begin
                    line_q  <= req_line;
                    pf_q    <= req_pf;
                    wr_q    <= req_wr;
                    state_q <= S_LOOKUP;
                end
                S_LOOKUP: begin
                    if (lk_hit[0])      begin src_q <= SRC_L1;  state_q <= S_FIN;    end
                    else if (lk_hit[1]) begin src_q <= SRC_L2;  state_q <= S_L1FILL; end
                    else if (lk_hit[2]) begin src_q <= SRC_L3;  state_q <= S_L2FILL; end
                    else                begin src_q <= SRC_MEM; state_q <= S_MEMRD;  end
                end
                S_MEMRD: if (mem_rd_done) state_q <= S_L3FILL;
                S_L3FILL: begin
                    vic_q  <= occ_line[2];
                    inv1_q <= occ_valid[2] && lk_hit[0];
                    inv2_q <= occ_valid[2] && lk_hit[1];
                    wb_q   <= occ_valid[2] && (occ_dirty[2] || (lk_hit[0] && occ_dirty[0])
                                               || (lk_hit[1] && occ_dirty[1]));
                    if (occ_valid[2] && (lk_hit[0] || lk_hit[1])) state_q <= S_INVAL;
                    else if (occ_valid[2] && occ_dirty[2])        state_q <= S_MEMWR;
                    else                                          state_q <= S_L2FILL;
                end
                S_INVAL:  state_q <= wb_q ? S_MEMWR : S_L2FILL;
                S_MEMWR:  state_q <= S_L2FILL;
                S_L2FILL: state_q <= S_L1FILL;
                S_L1FILL: state_q <= S_FIN;
                S_FIN:    state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // Port drive derived from state and latched request data.
    always_comb begin
        busy         = (state_q != S_IDLE);
        done         = (state_q == S_FIN);
        done_src     = src_q;
        done_pf      = pf_q;
        mem_rd_valid = (state_q == S_MEMRD);
        mem_rd_line  = line_q;
        mem_wr_valid = (state_q == S_MEMWR);
        mem_wr_line  = vic_q;
        inv_valid    = (state_q == S_INVAL);
        inv_line     = vic_q;
        inv_l1       = inv1_q;
        inv_l2       = inv2_q;
    end
endmodule

// File: rtl/cic_checker.sv
// Protocol checker for cache_incl_ctrl, attached by bind below.
// Assumes: synchronous active-low reset; observes ports only.
module cic_checker #(
    parameter int LINE_W = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              done_pf,
    input logic              mem_rd_valid,
    input logic [LINE_W-1:0] mem_rd_line,
    input logic              mem_rd_done,
    input logic              mem_wr_valid,
    input logic [LINE_W-1:0] mem_wr_line,
    input logic              inv_valid,
    input logic [LINE_W-1:0] inv_line,
    input logic              inv_l1,
    input logic              inv_l2
);
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r1_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_line)));

    a_r1_read_in_request: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (busy && !done));

    a_r4_inv_names_level: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_l1 || inv_l2));

    a_r8_wb_same_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && $past(inv_valid)) |-> (mem_wr_line == $past(inv_line)));

    a_r6_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(done_pf));
endmodule

bind cache_incl_ctrl cic_checker #(.LINE_W(LINE_W)) u_cic_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .done_pf     (done_pf),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_line (mem_rd_line),
    .mem_rd_done (mem_rd_done),
    .mem_wr_valid(mem_wr_valid),
    .mem_wr_line (mem_wr_line),
    .inv_valid   (inv_valid),
    .inv_line    (inv_line),
    .inv_l1      (inv_l1),
    .inv_l2      (inv_l2)
);

// File: tb/tb_cache_incl_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_cache_incl_ctrl;
    localparam int LW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [LW-1:0] req_line = '0;
    logic          req_pf = 1'b0;
    logic          req_wr = 1'b0;
    logic          busy, done, done_pf;
    logic [1:0]    done_src;
    logic          mem_rd_valid, mem_wr_valid, inv_valid, inv_l1, inv_l2;
    logic [LW-1:0] mem_rd_line, mem_wr_line, inv_line;
    logic          mem_rd_done = 1'b0;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int n_inv, n_wr, n_rd, inv_cyc, wr_cyc, busy_cnt, done_cnt;
    logic [LW-1:0] inv_a, wr_a, rd_a;
    logic i1, i2, rd_prev = 1'b0;
    int rd_cnt = 0;
    logic [1:0] got_src;
    logic got_pf;

    cache_incl_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_pf(req_pf), .req_wr(req_wr), .busy(busy), .done(done),
        .done_src(done_src), .done_pf(done_pf), .mem_rd_valid(mem_rd_valid),
        .mem_rd_line(mem_rd_line), .mem_rd_done(mem_rd_done),
        .mem_wr_valid(mem_wr_valid), .mem_wr_line(mem_wr_line),
        .inv_valid(inv_valid), .inv_line(inv_line), .inv_l1(inv_l1), .inv_l2(inv_l2)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: answer each read three cycles after it appears.
    always @(negedge clk) begin
        if (mem_rd_done) mem_rd_done <= 1'b0;
        else if (mem_rd_valid) begin
            if (rd_cnt == 2) begin mem_rd_done <= 1'b1; rd_cnt <= 0; end
            else rd_cnt <= rd_cnt + 1;
        end
    end

    // Event monitor for invalidations, write-backs and read starts.
    always @(negedge clk) begin
        if (inv_valid) begin n_inv++; inv_a = inv_line; i1 = inv_l1; i2 = inv_l2; inv_cyc = cyc; end
        if (mem_wr_valid) begin n_wr++; wr_a = mem_wr_line; wr_cyc = cyc; end
        if (mem_rd_valid && !rd_prev) begin n_rd++; rd_a = mem_rd_line; end
        rd_prev = mem_rd_valid;
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run hung (actual=timeout expected=completion)");
        finish_run();
    end

    task automatic chk(string rq, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic clr_ev();
        n_inv = 0; n_wr = 0; n_rd = 0; busy_cnt = 0; done_cnt = 0;
    endtask

    // Issue one request and wait for done; records source, flag and busy length.
    task automatic do_req(int line, bit pf, bit wr);
        clr_ev();
        @(negedge clk);
        req_valid = 1'b1; req_line = LW'(line); req_pf = pf; req_wr = wr;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (busy) busy_cnt++;
            if (done) begin got_src = done_src; got_pf = done_pf; return; end
        end
        chk("R9", "done timeout", 0, 1);
    endtask

    task automatic req_src(string rq, int line, int exp);
        do_req(line, 1'b0, 1'b0);
        chk(rq, $sformatf("source for line %0d", line), got_src, exp);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R10", "busy after reset", busy, 0);
        chk("R10", "done after reset", done, 0);
        chk("R10", "mem_rd_valid after reset", mem_rd_valid, 0);
        chk("R10", "mem_wr_valid after reset", mem_wr_valid, 0);
        req_src("R10", 5, 3);
        chk("R1", "memory read line", rd_a, 5);
        chk("R9", "busy cycles on clean miss", busy_cnt, 8);
        @(negedge clk);
        chk("R9", "busy low after done", busy, 0);
    endtask

    task automatic t_levels();
        do_reset();
        req_src("R1", 1, 3);
        req_src("R2", 1, 0);
        chk("R1", "no memory read on hit", n_rd, 0);
        chk("R9", "busy cycles on first-level hit", busy_cnt, 2);
        req_src("R3", 9, 3);
        req_src("R2", 1, 1);
        chk("R1", "no memory read on second-level hit", n_rd, 0);
        req_src("R3", 16, 3);
        chk("R5", "no invalidation on second-level eviction", n_inv, 0);
        req_src("R5", 1, 0);
        req_src("R3", 9, 1);
        req_src("R2", 1, 2);
        chk("R1", "no memory read on third-level hit", n_rd, 0);
    endtask

    task automatic t_back_inval();
        do_reset();
        req_src("R4", 2, 3);
        req_src("R4", 34, 3);
        chk("R4", "invalidation count", n_inv, 1);
        chk("R4", "invalidated line", inv_a, 2);
        chk("R4", "first level held", i1, 1);
        chk("R4", "second level held", i2, 1);
        chk("R8", "clean victim writes nothing", n_wr, 0);
        req_src("R4", 2, 3);
        do_reset();
        req_src("R4", 2, 3);
        req_src("R4", 10, 3);
        req_src("R4", 34, 3);
        chk("R4", "only second level: l1 flag", i1, 0);
        chk("R4", "only second level: l2 flag", i2, 1);
        do_reset();
        req_src("R4", 2, 3);
        req_src("R5", 19, 3);
        req_src("R4", 34, 3);
        chk("R4", "only first level: l1 flag", i1, 1);
        chk("R4", "only first level: l2 flag", i2, 0);
    endtask

    task automatic t_dirty();
        do_reset();
        do_req(2, 1'b0, 1'b1);
        req_src("R8", 34, 3);
        chk("R8", "write-back count", n_wr, 1);
        chk("R8", "write-back line", wr_a, 2);
        chk("R8", "write after invalidation", (wr_cyc > inv_cyc), 1);
        do_reset();
        req_src("R7", 2, 3);
        do_req(2, 1'b0, 1'b1);
        chk("R7", "store hit source", got_src, 0);
        req_src("R7", 34, 3);
        chk("R7", "store hit later written back", n_wr, 1);
        do_reset();
        do_req(2, 1'b0, 1'b1);
        req_src("R7", 19, 3);
        req_src("R7", 10, 3);
        chk("R7", "no write while lines stay cached", n_wr, 0);
        req_src("R7", 34, 3);
        chk("R7", "no invalidation of absent victim", n_inv, 0);
        chk("R7", "dirty pushed to third level then written", n_wr, 1);
        chk("R7", "written line", wr_a, 2);
        do_reset();
        do_req(2, 1'b0, 1'b1);
        req_src("R11", 10, 3);
        req_src("R11", 19, 3);
        req_src("R11", 34, 3);
        chk("R11", "dirty via second level written", n_wr, 1);
        chk("R11", "written line", wr_a, 2);
    endtask

    task automatic t_prefetch();
        do_reset();
        do_req(5, 1'b1, 1'b0);
        chk("R6", "prefetch source", got_src, 3);
        chk("R6", "prefetch flag echoed", got_pf, 1);
        chk("R6", "prefetch read issued", n_rd, 1);
        do_req(5, 1'b0, 1'b0);
        chk("R6", "demand after prefetch source", got_src, 0);
        chk("R6", "demand flag echoed", got_pf, 0);
    endtask

    task automatic t_busy_ignore();
        do_reset();
        clr_ev();
        @(negedge clk);
        req_valid = 1'b1; req_line = LW'(5); req_pf = 1'b0; req_wr = 1'b0;
        for (int k = 0; k < 14; k++) begin
            @(negedge clk);
            if (k == 2) begin req_valid = 1'b1; req_line = LW'(7); end
            else req_valid = 1'b0;
            if (done) done_cnt++;
        end
        chk("R9", "one completion for one accepted request", done_cnt, 1);
        chk("R9", "busy low at end", busy, 0);
        chk("R9", "one memory read", n_rd, 1);
        req_src("R9", 7, 3);
        req_src("R9", 5, 0);
    endtask

    initial begin
        t_reset_state();
        t_levels();
        t_back_inval();
        t_dirty();
        t_prefetch();
        t_busy_ignore();
        finish_run();
    end
endmodule